// File: doc/BRIEF.md
# Dual-Modulus Swallow Counter Controller

This block is the programmable divider stage of a frequency synthesizer that uses an external two-ratio prescaler. The prescaler can divide by 64 or by 65. Its output pulses come into this block, which counts them with two counters that share the same pulse stream. A cycle starts with the prescaler set to divide by 64. After N pulses, the first counter switches the prescaler to divide by 65. After N + A pulses in total, the second counter ends the cycle: it toggles the divided output, returns the prescaler to divide by 64, and clears both counters. The overall division ratio is therefore set by N and A.

The pulse input is asynchronous to the system clock. It goes through a synchronizer and a rising-edge detector, so each prescaler pulse advances the counters by exactly one. The system clock must run at least four times the pulse rate.

The value of A can be changed while the block runs, to retune the synthesizer. N and A are sampled only at reset and on the pulse that completes a cycle, so a cycle that is already under way always finishes with the values it started with. The default settings are N = 4 and A = 20.

Top module: `swallow_ctrl`

## Requirements
- R1: While reset is asserted, and on the first clock after it, mod_sel is 0 (divide-by-64), div_out is 0 and done is 0. Reset also clears both counters and loads n_val and a_val as the active values.
- R2: mod_sel is 0 (divide-by-64) from the start of a cycle until the Nth counted pulse of that cycle.
- R3: On the Nth counted pulse, mod_sel changes to 1 (divide-by-65). It stays at 1 for the next A pulses, up to but not including the pulse that completes the cycle.
- R4: On the (N+A)th counted pulse, div_out toggles, mod_sel returns to 0 and both counters restart, so the next cycle counts from one again.
- R5: done is high for exactly one clock each time div_out toggles, and is low at all other times.
- R6: A value written to a_val in the middle of a cycle does not change the length of that cycle. It is applied from the next cycle onward.
- R7: With A = 0, mod_sel stays at 0 for the whole cycle, and div_out toggles every N pulses.
- R8: N = 0 behaves exactly like N = 1.
- R9: A pulse counts once per rising edge of pulse_in, however long pulse_in stays high. The outputs settle no later than the third clock edge after pulse_in rises.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| pulse_in | input | 1 | Prescaler output pulse, asynchronous to clk |
| n_val | input | CNT_W | Number of divide-by-64 pulses per cycle (N) |
| a_val | input | CNT_W | Number of divide-by-65 pulses per cycle (A), may change at run time |
| mod_sel | output | 1 | Prescaler ratio select: 0 = divide by 64, 1 = divide by 65 |
| div_out | output | 1 | Divided output, toggles once per completed cycle |
| done | output | 1 | One-clock strobe on each div_out toggle |

## Verification
The bench changes a_val one pulse into a cycle. A design that loads A immediately would end that cycle at the wrong pulse count, and the bench would see it. It also runs with A = 0 and with N = 0. Here a design that compares counters carelessly would assert divide-by-65 for a stray pulse, or would never end the cycle because a zero target cannot be reached. It holds pulse_in high for many clocks, which exposes a missing edge detector through extra counts. Finally, it counts done strobes against the toggles of div_out, which catches a strobe that lasts too long or does not appear at all.

// File: rtl/swallow_pkg.sv
package swallow_pkg;

    typedef enum logic {
        MOD_LOW  = 1'b0,
        MOD_HIGH = 1'b1
    } mod_e;

endpackage

// File: rtl/swallow_edge.sv
module swallow_edge #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic pulse_in,
    output logic cnt_en
);

    localparam int SHW = STAGES + 1;

    logic [SHW-1:0] sh_d;
    logic [SHW-1:0] sh_q;

    generate
        if (STAGES < 2) begin : g_bad_depth
            initial $error("swallow_edge: STAGES must be at least 2");
        end
    endgenerate

    always_comb begin
        sh_d = {sh_q[SHW-2:0], pulse_in};
    end

    always_ff @(posedge clk) begin
        if (rst) sh_q <= '0;
        else     sh_q <= sh_d;
    end

    assign cnt_en = sh_q[STAGES-1] & ~sh_q[STAGES];

endmodule

// File: rtl/swallow_count.sv
module swallow_count
    import swallow_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cnt_en,
    input  logic [CNT_W-1:0] n_val,
    input  logic [CNT_W-1:0] a_val,
    output logic             mod_sel,
    output logic             cyc_end
);

    localparam int TW = CNT_W + 1;

    typedef struct packed {
        logic [CNT_W-1:0] n_cnt;
        logic [TW-1:0]    tot;
        logic [CNT_W-1:0] n_act;
        logic [CNT_W-1:0] a_act;
        mod_e             mode;
    } st_t;

    st_t st_d, st_q;

    logic [CNT_W-1:0] n_eff;
    logic [TW-1:0]    tot_lim;
    logic [TW-1:0]    tot_nx;
    logic [CNT_W-1:0] n_nx;

    always_comb begin
        n_eff   = (st_q.n_act == '0) ? CNT_W'(1) : st_q.n_act;
        tot_lim = {1'b0, n_eff} + {1'b0, st_q.a_act};
        tot_nx  = st_q.tot + TW'(1);
        n_nx    = st_q.n_cnt + CNT_W'(1);
        st_d    = st_q;
        cyc_end = 1'b0;
        if (cnt_en) begin
            if (tot_nx == tot_lim) begin
                cyc_end    = 1'b1;
                st_d.tot   = '0;
                st_d.n_cnt = '0;
                st_d.mode  = MOD_LOW;
                st_d.n_act = n_val;
                st_d.a_act = a_val;
            end else begin
                st_d.tot = tot_nx;
                if (st_q.n_cnt != n_eff) begin
                    st_d.n_cnt = n_nx;
                    if (n_nx == n_eff) st_d.mode = MOD_HIGH;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q.n_cnt <= '0;
            st_q.tot   <= '0;
            st_q.n_act <= n_val;
            st_q.a_act <= a_val;
            st_q.mode  <= MOD_LOW;
        end else begin
            st_q <= st_d;
        end
    end

    assign mod_sel = st_q.mode;

endmodule

// File: rtl/swallow_out.sv
module swallow_out (
    input  logic clk,
    input  logic rst,
    input  logic cyc_end,
    output logic div_out,
    output logic done
);

    typedef struct packed {
        logic div;
        logic stb;
    } out_t;

    out_t o_d, o_q;

    always_comb begin
        o_d.div = o_q.div ^ cyc_end;
        o_d.stb = cyc_end;
    end

    always_ff @(posedge clk) begin
        if (rst) o_q <= '0;
        else     o_q <= o_d;
    end

    assign div_out = o_q.div;
    assign done    = o_q.stb;

endmodule

// File: rtl/swallow_ctrl.sv
module swallow_ctrl #(
    parameter int CNT_W       = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             pulse_in,
    input  logic [CNT_W-1:0] n_val,
    input  logic [CNT_W-1:0] a_val,
    output logic             mod_sel,
    output logic             div_out,
    output logic             done
);

    logic cnt_en;
    logic cyc_end;

    swallow_edge #(.STAGES(SYNC_STAGES)) u_edge (
        .clk      (clk),
        .rst      (rst),
        .pulse_in (pulse_in),
        .cnt_en   (cnt_en)
    );

    swallow_count #(.CNT_W(CNT_W)) u_count (
        .clk     (clk),
        .rst     (rst),
        .cnt_en  (cnt_en),
        .n_val   (n_val),
        .a_val   (a_val),
        .mod_sel (mod_sel),
        .cyc_end (cyc_end)
    );

    swallow_out u_out (
        .clk     (clk),
        .rst     (rst),
        .cyc_end (cyc_end),
        .div_out (div_out),
        .done    (done)
    );

endmodule

// File: rtl/swallow_ctrl_chk.sv
module swallow_ctrl_chk (
    input logic clk,
    input logic rst,
    input logic mod_sel,
    input logic div_out,
    input logic done
);

    AST_RESET_STATE: assert property (@(posedge clk)
        rst |=> (!mod_sel && !div_out && !done)); // R1

    AST_MOD_RISE_NOT_END: assert property (@(posedge clk) disable iff (rst)
        $rose(mod_sel) |-> !done); // R3

    AST_END_MOD_LOW: assert property (@(posedge clk) disable iff (rst)
        done |-> !mod_sel); // R4

    AST_DIV_HOLDS: assert property (@(posedge clk) disable iff (rst)
        !done |-> $stable(div_out)); // R4

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        done |=> !done); // R5

    AST_DONE_TOGGLES: assert property (@(posedge clk) disable iff (rst)
        done |-> (div_out != $past(div_out))); // R5

endmodule

bind swallow_ctrl swallow_ctrl_chk u_chk (
    .clk     (clk),
    .rst     (rst),
    .mod_sel (mod_sel),
    .div_out (div_out),
    .done    (done)
);

// File: tb/swallow_ctrl_bench.sv
module swallow_ctrl_bench;

    localparam int W = 8;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         pulse_in = 1'b0;
    logic [W-1:0] n_val = 8'd4;
    logic [W-1:0] a_val = 8'd20;
    logic         mod_sel, div_out, done;

    int checks = 0;
    int errors = 0;
    int done_cnt = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    swallow_ctrl #(.CNT_W(W)) u_swallow_ctrl (
        .clk(clk), .rst(rst), .pulse_in(pulse_in),
        .n_val(n_val), .a_val(a_val),
        .mod_sel(mod_sel), .div_out(div_out), .done(done)
    );

    always @(negedge clk) if (!rst && done) done_cnt++;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic do_reset(input int n, input int a);
        @(negedge clk);
        rst = 1'b1; n_val = W'(n); a_val = W'(a); pulse_in = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
    endtask

    task automatic pulse();
        pulse_in = 1'b1;
        repeat (4) @(negedge clk);
        pulse_in = 1'b0;
        repeat (4) @(negedge clk);
    endtask

    // Runs one full cycle with effective n, a and checks mod_sel after every pulse.
    task automatic run_cycle(input int n, input int a, input string tag);
        int start_div = div_out;
        int start_done = done_cnt;
        for (int k = 1; k <= n + a; k++) begin
            pulse();
            if (k < n + a) begin
                chk(mod_sel == ((k >= n) ? 1'b1 : 1'b0), tag, mod_sel, (k >= n) ? 1 : 0);
                chk(div_out == start_div, tag, div_out, start_div);
            end
        end
        chk(mod_sel == 1'b0, tag, mod_sel, 0);
        chk(div_out != start_div, tag, div_out, !start_div);
        chk(done_cnt == start_done + 1, {tag, " R5 done count"}, done_cnt - start_done, 1);
    endtask

    task automatic t_reset();
        rst = 1'b1;
        repeat (3) @(negedge clk);
        chk(mod_sel == 0 && div_out == 0 && done == 0, "R1 in reset",
            {mod_sel, div_out, done}, 0);
        rst = 1'b0;
        @(negedge clk);
        chk(mod_sel == 0 && div_out == 0 && done == 0, "R1 after reset",
            {mod_sel, div_out, done}, 0);
    endtask

    task automatic t_basic();
        do_reset(3, 2);
        chk(mod_sel == 0, "R2 start of cycle", mod_sel, 0);
        run_cycle(3, 2, "R2 R3 R4 basic c1");
        run_cycle(3, 2, "R4 basic c2");
    endtask

    task automatic t_defaults();
        do_reset(4, 20);
        run_cycle(4, 20, "R3 R4 default");
    endtask

    task automatic t_midchange();
        int start_div;
        do_reset(2, 2);
        start_div = div_out;
        pulse();
        a_val = 8'd5;
        chk(mod_sel == 0, "R6 first pulse", mod_sel, 0);
        pulse();
        chk(mod_sel == 1, "R6 second pulse", mod_sel, 1);
        pulse();
        chk(div_out == start_div, "R6 no early end", div_out, start_div);
        pulse();
        chk(div_out != start_div, "R6 old length kept", div_out, !start_div);
        run_cycle(2, 5, "R6 new A next cycle");
    endtask

    task automatic t_a_zero();
        do_reset(3, 0);
        run_cycle(3, 0, "R7 A zero c1");
        run_cycle(3, 0, "R7 A zero c2");
    endtask

    task automatic t_n_zero();
        do_reset(0, 2);
        run_cycle(1, 2, "R8 N zero");
    endtask

    task automatic t_held();
        int start_div;
        do_reset(1, 1);
        start_div = div_out;
        pulse_in = 1'b1;
        repeat (40) @(negedge clk);
        chk(mod_sel == 1 && div_out == start_div, "R9 held high counts once",
            {mod_sel, div_out}, {1'b1, start_div[0]});
        pulse_in = 1'b0;
        repeat (4) @(negedge clk);
        // latency: rise just before edge 1, settled after edge 3
        pulse_in = 1'b1;
        repeat (3) @(posedge clk);
        #1;
        chk(div_out != start_div, "R9 latency three edges", div_out, !start_div);
        @(negedge clk);
        pulse_in = 1'b0;
        repeat (4) @(negedge clk);
    endtask

    initial begin
        t_reset();
        t_basic();
        t_defaults();
        t_midchange();
        t_a_zero();
        t_n_zero();
        t_held();
        finished = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule